// File: doc/BRIEF.md
# Asynchronous External Bus Cycle Sequencer

This block turns an internal access request into the strobe sequence an asynchronous external memory or peripheral expects, such as SRAM, NOR flash or a memory-mapped I/O chip. A request carries a word address, a read/write flag, a burst-length code and one write data word. The same cycle it is accepted, the block also samples a 16-bit timing word for the addressed area and a global 2-bit wait-reduction code. It then drives address, an active-low chip select and an active-low read or write strobe. It counts the programmed wait clocks, optionally stretches each beat with an external ready input, and returns one response per beat. A read response carries the data captured at the end of the beat.

Bursts run in page mode. The chip select and the strobe stay asserted across all beats. Only the low address bits step, and they wrap within an aligned window of 1, 2, 4 or 8 words. The first beat and the later beats have separate wait counts. Optional single-clock extensions are available around the strobe: address-to-select delay, select-to-strobe setup and select hold. Optional idle gaps are also available: write recovery after a write, and turnaround before a write that follows a read. All four gaps and extensions are taken from the area configuration.

The controller states are `ST_IDLE`, `ST_TURN`, `ST_ADDR`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD` and `ST_RECOV`. The transitions are:
- `ST_IDLE` accepts a request. It goes to `ST_TURN` when the request is a write, the previous cycle was a read and that read's turnaround field is non-zero. Otherwise it goes to the entry state. The entry state is `ST_ADDR` if the delay bit is set, else `ST_SETUP` if the setup bit is set, else `ST_STROBE`.
- `ST_TURN` goes to the entry state when its gap counter runs out.
- `ST_ADDR` goes to `ST_SETUP` or to `ST_STROBE`.
- `ST_SETUP` goes to `ST_STROBE`.
- `ST_STROBE` loops until the final beat completes. It then goes to `ST_HOLD` if the hold bit is set. Otherwise it goes to `ST_RECOV` for a write with non-zero recovery, or else to `ST_IDLE`.
- `ST_HOLD` goes to `ST_RECOV` or to `ST_IDLE` by the same rule.
- `ST_RECOV` goes to `ST_IDLE` when its gap counter runs out.

Top module: `ebus_cycle_seq`

## Requirements
- R1: After reset the chip select and both strobes are high (inactive), `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is 1 only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: The first beat keeps its strobe low for W+1 clocks when the ready wait is off. W is the first-access wait count in `cfg_wait[3:0]` (0..15).
- R3: Each later beat of a burst keeps the strobe low for P+1 clocks, where P is the in-page wait count in `cfg_wait[7:4]`. Chip select and strobe stay low between beats, with no repeated setup clock, and the address is stable within a beat.
- R4: `req_burst` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Beat j drives address `(A & ~M) | ((A + j) & M)`, where M = beats - 1. `rsp_last` is 1 only with the final beat's response.
- R5: When `cfg_wait[12]` is 1, exactly one clock with chip select low and both strobes high comes before the strobe.
- R6: When `cfg_wait[13]` is 1, exactly one clock with chip select low and both strobes high follows the final beat.
- R7: When `cfg_wait[14]` is 1, exactly one clock with the address driven and chip select high comes before chip select falls.
- R8: After a write, `cfg_wait[9:8]` (0..3) idle clocks with chip select high pass before `req_ready` returns.
- R9: A write that directly follows a read is preceded by N idle clocks, all with chip select high. N is the read's `cfg_wait[11:10]` (0..3). No such gap is inserted after a write.
- R10: When `cfg_wait[15]` is 1, a beat whose wait count has expired is extended while `bus_rdy` is 0. `bus_rdy` has no effect while the count is non-zero, or when `cfg_wait[15]` is 0.
- R11: Both wait counts are shifted right by `cfg_reduce` (0..3), which divides them by 1, 2, 4 or 8 with truncation. The setup, hold, delay, recovery and turnaround clocks are not scaled.
- R12: A read strobes `bus_rd_n` and a write strobes `bus_wr_n`, never both. The write strobe drives `req_wdata` on `bus_wdata`. Each beat yields `rsp_valid` in the clock after its last strobe clock. For reads, `rsp_rdata` holds `bus_rdata` as sampled on the edge that ended the beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of first beat |
| req_burst | input | 2 | Burst code: beats = 2^code |
| req_wdata | input | DATA_W | Write data, driven on every beat |
| cfg_wait | input | 16 | Area timing word, sampled with the request |
| cfg_reduce | input | 2 | Global wait-reduction shift |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | External write data |
| bus_rdy | input | 1 | External ready, 1 = ready |
| bus_rdata | input | DATA_W | External read data |
| rsp_valid | output | 1 | One-clock pulse per completed beat |
| rsp_last | output | 1 | Marks the final beat's response |
| rsp_rdata | output | DATA_W | Read data of the completed beat |

## Verification
Counting from the clock edge that accepts a request, the strobe pins take values that follow the state sequence one clock per state. A strobe beat lasts its scaled wait count plus one clock, plus any clocks in which ready was low after the count expired. Each response appears exactly one clock after the last strobe clock of its beat. The bench walks the same sequence one clock at a time from the fields it drove. It samples every output at the falling edge, so the pins and any due response are compared in each busy clock and in the first idle clock after it. Ready is randomised in every clock, including those where it must be ignored, so an early or unconditional sample shows up as a shifted response.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

    localparam int WAIT_W = 4;
    localparam int GAP_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic              rdy_en;
        logic              addr_dly;
        logic              hold_ext;
        logic              setup_ext;
        logic [GAP_W-1:0]  turn;
        logic [GAP_W-1:0]  recov;
        logic [WAIT_W-1:0] page_w;
        logic [WAIT_W-1:0] first_w;
    } area_cfg_t;

endpackage

// File: rtl/ebus_cfg_decode.sv
module ebus_cfg_decode
    import ebus_seq_pkg::*;
(
    input  logic [15:0] raw,
    input  logic [1:0]  reduce,
    output area_cfg_t   cfg
);

    always_comb begin
        cfg.first_w   = raw[3:0] >> reduce;
        cfg.page_w    = raw[7:4] >> reduce;
        cfg.recov     = raw[9:8];
        cfg.turn      = raw[11:10];
        cfg.setup_ext = raw[12];
        cfg.hold_ext  = raw[13];
        cfg.addr_dly  = raw[14];
        cfg.rdy_en    = raw[15];
    end

endmodule

// File: rtl/ebus_down_timer.sv
module ebus_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ebus_burst_addr.sv
module ebus_burst_addr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        code,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam int CNT_W = 3;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  mask_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] wide_mask;

    assign wide_mask = {{(ADDR_W-CNT_W){1'b0}}, mask_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= base;
            mask_q <= (CNT_W'(1) << code) - CNT_W'(1);
            left_q <= (CNT_W'(1) << code) - CNT_W'(1);
        end else if (adv) begin
            addr_q <= (addr_q & ~wide_mask) | ((addr_q + 1'b1) & wide_mask);
            left_q <= left_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (left_q == '0);

endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
    import ebus_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [15:0]       cfg_wait,
    input  logic [1:0]        cfg_reduce,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_rdata
);

    seq_state_e        state, nxt;
    area_cfg_t         dec_cfg, cfg_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept, beat_done, last_beat;
    logic              wait_zero, gap_zero;
    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;

    function automatic seq_state_e entry_of(area_cfg_t c);
        if (c.addr_dly)       return ST_ADDR;
        else if (c.setup_ext) return ST_SETUP;
        else                  return ST_STROBE;
    endfunction

    function automatic seq_state_e after_hold(area_cfg_t c, logic wr);
        return (wr && c.recov != '0) ? ST_RECOV : ST_IDLE;
    endfunction

    ebus_cfg_decode u_decode (
        .raw    (cfg_wait),
        .reduce (cfg_reduce),
        .cfg    (dec_cfg)
    );

    assign accept    = (state == ST_IDLE) && req_valid;
    assign beat_done = (state == ST_STROBE) && wait_zero && (!cfg_q.rdy_en || bus_rdy);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write && !wr_q && cfg_q.turn != '0) nxt = ST_TURN;
                    else                                        nxt = entry_of(dec_cfg);
                end
            end
            ST_TURN:   if (gap_zero) nxt = entry_of(cfg_q);
            ST_ADDR:   nxt = cfg_q.setup_ext ? ST_SETUP : ST_STROBE;
            ST_SETUP:  nxt = ST_STROBE;
            ST_STROBE: begin
                if (beat_done && last_beat)
                    nxt = cfg_q.hold_ext ? ST_HOLD : after_hold(cfg_q, wr_q);
            end
            ST_HOLD:   nxt = after_hold(cfg_q, wr_q);
            ST_RECOV:  if (gap_zero) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // request capture and response stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                cfg_q   <= dec_cfg;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            rsp_valid <= beat_done;
            rsp_last  <= beat_done && last_beat;
            if (beat_done && !wr_q) rsp_rdata <= bus_rdata;
        end
    end

    // gap counter: turnaround uses the previous area, recovery the current one
    assign gap_load = ((nxt == ST_TURN) && (state != ST_TURN)) ||
                      ((nxt == ST_RECOV) && (state != ST_RECOV));
    assign gap_val  = (nxt == ST_TURN) ? cfg_q.turn - 2'd1 : cfg_q.recov - 2'd1;

    ebus_down_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .dec      ((state == ST_TURN) || (state == ST_RECOV)),
        .zero     (gap_zero)
    );

    // wait counter: first beat loaded at accept, later beats on advance
    assign wait_load = accept || (beat_done && !last_beat);
    assign wait_val  = accept ? dec_cfg.first_w : cfg_q.page_w;

    ebus_down_timer #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .dec      (state == ST_STROBE),
        .zero     (wait_zero)
    );

    ebus_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .base  (req_addr),
        .code  (req_burst),
        .adv   (beat_done && !last_beat),
        .addr  (bus_addr),
        .last  (last_beat)
    );

    // pin decode from state
    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_cs_n  = !((state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD));
        bus_rd_n  = !((state == ST_STROBE) && !wr_q);
        bus_wr_n  = !((state == ST_STROBE) && wr_q);
        bus_wdata = wdata_q;
    end

endmodule

// File: rtl/ebus_cycle_seq_chk.sv
module ebus_cycle_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rsp_valid,
    input logic              rsp_last
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n));

    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n) && !rsp_valid) |-> $stable(bus_addr));

    p_last_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n || bus_wr_n));

    p_rsp_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!bus_rd_n || !bus_wr_n));

endmodule

bind ebus_cycle_seq ebus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_addr  (bus_addr),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last)
);

// File: tb/ebus_cycle_seq_test.sv
`timescale 1ns/1ps
module ebus_cycle_seq_test;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_burst = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [15:0]   cfg_wait = '0;
    logic [1:0]    cfg_reduce = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_rd_n, bus_wr_n;
    logic [DW-1:0] bus_wdata;
    logic          bus_rdy = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          rsp_valid, rsp_last;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit pend = 0, pend_rd = 0, pend_l = 0;
    logic [DW-1:0] pend_d = '0;
    bit prev_rd = 0;
    logic [1:0] prev_turn = '0;

    always #4 clk = ~clk;

    ebus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_burst(req_burst), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .cfg_reduce(cfg_reduce),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
        .rsp_rdata(rsp_rdata)
    );

    function automatic logic [DW-1:0] mem_f(logic [AW-1:0] a);
        return a[15:0] ^ {8'h00, a[23:16]} ^ 16'h5A3C;
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] c, int j);
        logic [AW-1:0] m;
        m = AW'((1 << c) - 1);
        return (b & ~m) | ((b + AW'(j)) & m);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic resp_check();
        chk(rsp_valid == pend, "R12 response", "rsp_valid", rsp_valid, pend);
        if (pend && rsp_valid) begin
            chk(rsp_last == pend_l, "R4 last marker", "rsp_last", rsp_last, pend_l);
            if (pend_rd)
                chk(rsp_rdata == pend_d, "R12 read data", "rsp_rdata", rsp_rdata, pend_d);
        end
        pend = 0;
    endtask

    task automatic cyc(input logic ecs, input logic erd, input logic ewr,
                       input bit chk_a, input logic [AW-1:0] ea,
                       input bit chk_w, input logic [DW-1:0] ew, input string tag);
        chk({bus_cs_n, bus_rd_n, bus_wr_n} == {ecs, erd, ewr}, tag, "cs/rd/wr",
            {bus_cs_n, bus_rd_n, bus_wr_n}, {ecs, erd, ewr});
        chk(req_ready == 1'b0, tag, "req_ready busy", req_ready, 0);
        if (chk_a) chk(bus_addr == ea, tag, "bus_addr", bus_addr, ea);
        if (chk_w) chk(bus_wdata == ew, tag, "bus_wdata", bus_wdata, ew);
        resp_check();
        @(posedge clk);
        @(negedge clk);
        bus_rdy = 1'($urandom_range(0, 1));
    endtask

    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [1:0] bc,
                           input logic [15:0] cw, input logic [1:0] red,
                           input logic [DW-1:0] wd);
        int fw, pw, rec, trn, nb, cntm;
        bit su, ho, ad, re, done;
        logic [AW-1:0] ea;
        chk(req_ready && bus_cs_n && bus_rd_n && bus_wr_n, "R1 idle", "ready/cs/rd/wr",
            {req_ready, bus_cs_n, bus_rd_n, bus_wr_n}, 4'hF);
        resp_check();
        req_write = wr; req_addr = a; req_burst = bc; cfg_wait = cw;
        cfg_reduce = red; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wait = 16'($urandom);
        cfg_reduce = 2'($urandom);
        bus_rdy = 1'($urandom_range(0, 1));
        fw = int'(cw[3:0]) >> red;
        pw = int'(cw[7:4]) >> red;
        rec = int'(cw[9:8]);
        trn = int'(cw[11:10]);
        su = cw[12]; ho = cw[13]; ad = cw[14]; re = cw[15];
        nb = 1 << bc;
        if (wr && prev_rd && prev_turn != 0)
            repeat (int'(prev_turn)) cyc(1, 1, 1, 0, '0, 0, '0, "R9 turnaround");
        if (ad) cyc(1, 1, 1, 1, a, 0, '0, "R7 address delay");
        if (su) cyc(0, 1, 1, 1, a, 0, '0, "R5 setup");
        for (int j = 0; j < nb; j++) begin
            ea = beat_addr(a, bc, j);
            cntm = (j == 0) ? fw : pw;
            done = 0;
            while (!done) begin
                done = (cntm == 0) && (!re || bus_rdy);
                if (!done && cntm != 0) cntm--;
                cyc(0, wr, !wr, 1, ea, wr, wd,
                    (j == 0) ? "R2 R10 R11 first beat" : "R3 R4 page beat");
                if (done) begin
                    pend = 1; pend_rd = !wr; pend_d = mem_f(ea); pend_l = (j == nb - 1);
                end
            end
        end
        if (ho) cyc(0, 1, 1, 1, beat_addr(a, bc, nb - 1), 0, '0, "R6 hold");
        if (wr && rec != 0) repeat (rec) cyc(1, 1, 1, 0, '0, 0, '0, "R8 recovery");
        prev_rd = !wr;
        prev_turn = 2'(trn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && bus_cs_n && bus_rd_n && bus_wr_n && !rsp_valid, "R1 reset",
            "ready/cs/rd/wr/rsp", {req_ready, bus_cs_n, bus_rd_n, bus_wr_n, rsp_valid}, 5'h1E);

        // directed corners
        run_txn(0, 24'h000100, 2'd0, 16'h0000, 2'd0, 16'h0000);   // R2 zero wait
        run_txn(0, 24'h000200, 2'd0, 16'h000F, 2'd0, 16'h0000);   // R2 max wait
        run_txn(0, 24'h000300, 2'd0, 16'h000F, 2'd3, 16'h0000);   // R11 15>>3 = 1
        run_txn(0, 24'h12345E, 2'd2, 16'h0053, 2'd2, 16'h0000);   // R4 R11 wrap 2,3,0,1
        run_txn(0, 24'hABCDE5, 2'd3, 16'h0021, 2'd0, 16'h0000);   // R3 R4 8-beat wrap
        run_txn(0, 24'h000400, 2'd0, 16'h0C00, 2'd0, 16'h0000);   // read, turn 3
        run_txn(1, 24'h000401, 2'd1, 16'h0312, 2'd0, 16'hBEEF);   // R9 then R8
        run_txn(1, 24'h000500, 2'd0, 16'h7C01, 2'd0, 16'h1234);   // R5 R6 R7, no turn
        run_txn(0, 24'h000600, 2'd1, 16'h7000, 2'd1, 16'h0000);   // R5 R6 R7 read
        for (int k = 0; k < 6; k++)
            run_txn(k[0], 24'h000700 + AW'(k), 2'd1, 16'h8032, 2'd0, 16'h0F0F); // R10 on
        for (int k = 0; k < 4; k++)
            run_txn(0, 24'h000800 + AW'(k), 2'd0, 16'h0003, 2'd0, 16'h0000);   // R10 off

        // constrained random
        for (int k = 0; k < 250; k++)
            run_txn(1'($urandom), 24'($urandom), 2'($urandom), 16'($urandom),
                    2'($urandom), 16'($urandom));

        chk(req_ready && bus_cs_n, "R1 final idle", "ready/cs", {req_ready, bus_cs_n}, 2'b11);
        resp_check();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule